// File: doc/BRIEF.md
# RGB Light Source Enable Controller

This block gates three light-source channels (red, green, blue) for an image-capture front end. Each channel has a 3-bit current-level code held in a register, which the block passes on to an external current source. Each channel also has an on/off gate. The enable requests arrive without timing discipline. They are taken in only when the pixel sample strobe falls, so a light can switch only on a pixel boundary.

A protection stage adds up the current that the captured enables would draw. A code x stands for x+1 eighths of one channel's full scale. If the total over the enabled channels is more than the budget of 12 eighths (150% of one full-scale channel), every gate is held off. The same channels enabled one at a time still drive normally. A global power-up input held low forces every gate off. The current registers are loaded through a simple synchronous write port.

Top module: `light_enable_ctrl`

## Requirements
- R1: After reset, all three level codes read 0 and all three gates are off.
- R2: The enable requests are captured at the first clock edge that sees the sample strobe low after it was high in the previous cycle. The gates reflect the captured value right after that edge.
- R3: Changes on the enable requests have no effect unless a strobe falling edge occurs. This holds while the strobe stays low, stays high, or only rises.
- R4: A write with cfgWrEn high loads cfgData into the channel chosen by cfgSel (0 = red, 1 = green, 2 = blue), visible on that level output after the clock edge. cfgSel = 3 changes no register.
- R5: A channel's gate (driveGate bit 0 = red, bit 1 = green, bit 2 = blue) is on only while its captured enable is 1.
- R6: When the sum of (code+1) over the captured-enabled channels is more than 12, all gates are off. A sum of exactly 12 drives normally.
- R7: A single captured-enabled channel drives at any code.
- R8: With pwrUp low, all gates are off. The level codes are kept, and the gates return without a new strobe once pwrUp is high again.
- R9: The budget check uses the current register contents. A write that pushes the total of the already-enabled channels over 12 turns all gates off right after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwrUp | input | 1 | 1 = normal operation, 0 = all drive off |
| sampleStrobe | input | 1 | Pixel sample strobe, sampled by clk |
| enReq | input | 3 | Enable requests, bit 0 red, bit 1 green, bit 2 blue |
| cfgWrEn | input | 1 | Level register write enable |
| cfgSel | input | 2 | Register select, 0 red, 1 green, 2 blue, 3 none |
| cfgData | input | 3 | Level code to write |
| levelRed | output | 3 | Red current-level code |
| levelGreen | output | 3 | Green current-level code |
| levelBlue | output | 3 | Blue current-level code |
| driveGate | output | 3 | Per-channel on/off gate, bit 0 red, bit 1 green, bit 2 blue |

## Verification
Each wrong internal state shows up on driveGate one clock after the edge that caused it, or on a level output for a register fault. A captured enable that is stale or taken on the wrong strobe edge makes driveGate disagree with the request that was present at the falling edge. An error in the budget adder appears only for totals near 12. For that reason the bench uses totals of 12, 13 and 14, and it also drives current changes made while the channels stay enabled.

// File: rtl/light_enable_pkg.sv
package light_enable_pkg;
  localparam int NUM_CH = 3;
  localparam int SEL_W = 2;

  typedef struct packed {
    logic capture;
    logic wrEn;
    logic [SEL_W-1:0] wrSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/light_enable_seq.sv
module light_enable_seq
  import light_enable_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic sampleStrobe,
  input  logic cfgWrEn,
  input  logic [SEL_W-1:0] cfgSel,
  output ctrlStrobes_t strobes
);
  logic strobePrev;

  always_ff @(posedge clk) begin
    if (!rstN) strobePrev <= 1'b0;
    else       strobePrev <= sampleStrobe;
  end

  always_comb begin
    strobes.capture = strobePrev & ~sampleStrobe;
    strobes.wrEn    = cfgWrEn && (int'(cfgSel) < NUM_CH);
    strobes.wrSel   = cfgSel;
  end

  // R2
  capture_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> !strobes.capture);
endmodule

// File: rtl/light_enable_path.sv
module light_enable_path
  import light_enable_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int BUDGET_UNITS = 12
)(
  input  logic clk,
  input  logic rstN,
  input  logic pwrUp,
  input  ctrlStrobes_t strobes,
  input  logic [NUM_CH-1:0] enReq,
  input  logic [CODE_W-1:0] cfgData,
  output logic [NUM_CH-1:0][CODE_W-1:0] levelCode,
  output logic [NUM_CH-1:0] driveGate
);
  localparam int SUM_W = $clog2(NUM_CH * (2 ** CODE_W) + 1);

  logic [NUM_CH-1:0] enSync;
  logic [SUM_W-1:0] totalUnits;
  logic overBudget;

  always_ff @(posedge clk) begin
    if (!rstN)                enSync <= '0;
    else if (strobes.capture) enSync <= enReq;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_level
    always_ff @(posedge clk) begin
      if (!rstN) levelCode[ch] <= '0;
      else if (strobes.wrEn && int'(strobes.wrSel) == ch) levelCode[ch] <= cfgData;
    end

    // R4
    level_write_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.wrEn && int'(strobes.wrSel) == ch) |=> levelCode[ch] == $past(cfgData));
  end

  always_comb begin
    totalUnits = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (enSync[ch]) totalUnits = totalUnits + SUM_W'(levelCode[ch]) + SUM_W'(1);
    end
  end

  assign overBudget = int'(totalUnits) > BUDGET_UNITS;
  assign driveGate  = (pwrUp && !overBudget) ? enSync : '0;

  // R2
  capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> enSync == $past(enReq));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(enSync));
  // R5
  gate_subset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (driveGate & ~enSync) == '0);
  // R8
  power_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pwrUp |-> driveGate == '0);
  // R7
  single_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrUp && $countones(enSync) == 1) |-> driveGate == enSync);
endmodule

// File: rtl/light_enable_ctrl.sv
module light_enable_ctrl
  import light_enable_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int BUDGET_UNITS = 12
)(
  input  logic clk,
  input  logic rstN,
  input  logic pwrUp,
  input  logic sampleStrobe,
  input  logic [2:0] enReq,
  input  logic cfgWrEn,
  input  logic [1:0] cfgSel,
  input  logic [CODE_W-1:0] cfgData,
  output logic [CODE_W-1:0] levelRed,
  output logic [CODE_W-1:0] levelGreen,
  output logic [CODE_W-1:0] levelBlue,
  output logic [2:0] driveGate
);
  ctrlStrobes_t strobes;
  logic [NUM_CH-1:0][CODE_W-1:0] levelCode;

  light_enable_seq u_seq (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .strobes(strobes)
  );

  light_enable_path #(.CODE_W(CODE_W), .BUDGET_UNITS(BUDGET_UNITS)) u_path (
    .clk(clk), .rstN(rstN), .pwrUp(pwrUp), .strobes(strobes),
    .enReq(enReq), .cfgData(cfgData), .levelCode(levelCode), .driveGate(driveGate)
  );

  assign levelRed   = levelCode[0];
  assign levelGreen = levelCode[1];
  assign levelBlue  = levelCode[2];
endmodule

// File: tb/light_enable_ctrl_bench.sv
module light_enable_ctrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrUp = 1'b1;
  logic sampleStrobe = 1'b0;
  logic [2:0] enReq = 3'b000;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgSel = 2'd0;
  logic [2:0] cfgData = 3'd0;
  logic [2:0] levelRed, levelGreen, levelBlue, driveGate;
  int checkCnt = 0;
  int failCnt = 0;

  always #5 clk = ~clk;

  light_enable_ctrl u_light_enable_ctrl (
    .clk(clk), .rstN(rstN), .pwrUp(pwrUp), .sampleStrobe(sampleStrobe),
    .enReq(enReq), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .levelRed(levelRed), .levelGreen(levelGreen), .levelBlue(levelBlue),
    .driveGate(driveGate)
  );

  task automatic check(input string req, input logic [8:0] actual, input logic [8:0] expected);
    checkCnt++;
    if (actual !== expected) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, actual, expected);
    end
  endtask

  task automatic writeLevel(input logic [1:0] sel, input logic [2:0] code);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgData = code;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // falling strobe edge: capture at the posedge after strobe goes low
  task automatic fireStrobe(input logic [2:0] req);
    @(negedge clk);
    enReq = req; sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [8:0] levels();
    return {levelBlue, levelGreen, levelRed};
  endfunction

  task automatic testReset();
    @(negedge clk);
    check("R1 levels", levels(), 9'd0);
    check("R1 gates", {6'd0, driveGate}, 9'd0);
  endtask

  task automatic testWrite();
    writeLevel(2'd0, 3'd2);
    writeLevel(2'd1, 3'd3);
    writeLevel(2'd2, 3'd1);
    check("R4 write", levels(), {3'd1, 3'd3, 3'd2});
    writeLevel(2'd3, 3'd7);
    check("R4 sel3 ignored", levels(), {3'd1, 3'd3, 3'd2});
  endtask

  task automatic testNoStrobe();
    @(negedge clk);
    enReq = 3'b111;
    repeat (4) @(negedge clk);
    check("R3 strobe low", {6'd0, driveGate}, 9'd0);
    sampleStrobe = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 strobe rise", {6'd0, driveGate}, 9'd0);
    sampleStrobe = 1'b0;
    @(negedge clk);
    check("R2 capture all", {6'd0, driveGate}, 9'b111);
    enReq = 3'b000;
    repeat (3) @(negedge clk);
    check("R3 change after capture", {6'd0, driveGate}, 9'b111);
  endtask

  task automatic testSubset();
    fireStrobe(3'b010);
    check("R5 green only", {6'd0, driveGate}, 9'b010);
    fireStrobe(3'b101);
    check("R5 red blue", {6'd0, driveGate}, 9'b101);
  endtask

  task automatic testBudget();
    writeLevel(2'd0, 3'd7);
    writeLevel(2'd1, 3'd2);
    writeLevel(2'd2, 3'd0);
    fireStrobe(3'b111);
    check("R6 sum 12 drives", {6'd0, driveGate}, 9'b111);
    writeLevel(2'd2, 3'd1);
    check("R9 sum 13 after write", {6'd0, driveGate}, 9'b000);
    writeLevel(2'd1, 3'd3);
    check("R6 sum 14", {6'd0, driveGate}, 9'b000);
    writeLevel(2'd1, 3'd7);
    fireStrobe(3'b011);
    check("R6 two full 16", {6'd0, driveGate}, 9'b000);
  endtask

  task automatic testSingles();
    writeLevel(2'd2, 3'd7);
    fireStrobe(3'b001);
    check("R7 red alone", {6'd0, driveGate}, 9'b001);
    fireStrobe(3'b010);
    check("R7 green alone", {6'd0, driveGate}, 9'b010);
    fireStrobe(3'b100);
    check("R7 blue alone", {6'd0, driveGate}, 9'b100);
  endtask

  task automatic testPower();
    @(negedge clk);
    pwrUp = 1'b0;
    @(negedge clk);
    check("R8 power down gates", {6'd0, driveGate}, 9'd0);
    check("R8 levels kept", levels(), {3'd7, 3'd7, 3'd7});
    pwrUp = 1'b1;
    @(negedge clk);
    check("R8 restore", {6'd0, driveGate}, 9'b100);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++; checkCnt++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWrite();
    testNoStrobe();
    testSubset();
    testBudget();
    testSingles();
    testPower();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule